// File: doc/BRIEF.md
# Cache Hardware Flush Sequencer

This block empties a two-way set-associative cache of its modified data without any per-line work from software. Once software raises the flush control bit, the sequencer walks the tag array one set at a time. It covers every index of way 0 in ascending order, then returns to index 0 and covers every index of way 1. For each line it reads the tag entry and raises one castout request per modified 32-byte sector, in ascending sector order. It waits on each request until the write queue acknowledges it. It then writes the entry back as invalid.

While the walk is running, the block holds off all level-one cache traffic. Snoop lookups keep full priority on the tag port. A cycle that a snoop takes is simply repeated by the sequencer. When the last entry has been invalidated, the control bit clears itself. At that point the tags are clean, but castouts may still be waiting in the bus-side queue. Software must use its own ordering barrier to be sure they have reached the bus.

The tag array is outside the block and answers reads combinationally. The castout address is a byte address built from the stored tag, the set index and the sector number, with the 5 low offset bits at zero.

Top module: `cflush_top`

## Requirements
- R1: After reset, `flush_active`, `l1_block`, `co_req`, `tag_rd_en` and `tag_inv_en` are all 0.
- R2: A one-cycle pulse on `flush_set` while idle makes `flush_active` 1 after the next clock edge. `flush_active` stays 1 until the walk ends.
- R3: Tag reads cover (way, index) pairs in the order way 0 index 0..2^IDX_W-1, then way 1 index 0..2^IDX_W-1. Each pair is read exactly once per flush (`tag_way` is 0 or 1, `tag_idx` is the set number).
- R4: For each read entry with valid=1, each sector whose dirty bit is 1 yields exactly one castout, in ascending sector order. Bit s of `tag_rd_dirty` belongs to sector s. The castout sets `co_way` to the way and `co_addr` = {tag, index, sector, 5'b0}. Clean sectors and invalid entries yield none.
- R5: Once `co_req` is 1 without `co_ack`, it stays 1 with `co_addr` and `co_way` unchanged until the cycle in which `co_ack` is 1.
- R6: Each entry is invalidated through `tag_inv_en` exactly once, after its castouts, in the same order as R3. After the flush, no entry is valid.
- R7: `snoop_gnt` follows `snoop_req` in every cycle. In a cycle with `snoop_req`=1, the sequencer drives neither `tag_rd_en` nor `tag_inv_en`, and it performs that access in a later cycle.
- R8: `flush_active` falls in the cycle after the invalidation of way 1, last index. A `flush_set` pulse while the flush is active has no effect: the walk is not restarted or extended, and no second flush follows.
- R9: `l1_block` is 1 exactly while `flush_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_set | input | 1 | Software write of 1 to the flush control bit |
| flush_active | output | 1 | Flush control bit state, self-clearing |
| l1_block | output | 1 | Stall for level-one cache requests |
| snoop_req | input | 1 | Snoop wants the tag port this cycle |
| snoop_gnt | output | 1 | Snoop owns the tag port this cycle |
| tag_rd_en | output | 1 | Sequencer tag read strobe |
| tag_inv_en | output | 1 | Sequencer tag invalidate strobe |
| tag_way | output | 1 | Way addressed on the tag port |
| tag_idx | output | IDX_W | Set index addressed on the tag port |
| tag_rd_valid | input | 1 | Valid bit of the addressed entry |
| tag_rd_dirty | input | SECTORS | Per-sector dirty bits of the addressed entry |
| tag_rd_tag | input | TAG_W | Stored tag of the addressed entry |
| co_req | output | 1 | Castout request |
| co_way | output | 1 | Way of the castout line |
| co_addr | output | TAG_W+IDX_W+log2(SECTORS)+5 | Byte address of the castout sector |
| co_ack | input | 1 | Write queue accepts the castout |

## Verification
A wrong walk counter shows on the tag port at the first read that goes astray: a skipped set, a set read twice, or a way switch at the wrong index. Each of these is caught the same cycle. A wrong sector pointer or a lost dirty bit shows as a castout address or a castout count that does not match the scoreboard. A count mismatch may only appear at the end, when the queue is left non-empty. A control state that ignores snoops or acknowledges shows in the first snoop or stalled cycle after it. A premature or missing self-clear is seen when `flush_active` falls with reads still due, or never falls before the timeout.

// File: rtl/cflush_pkg.sv
package cflush_pkg;

    localparam int SECTOR_BYTES = 32;
    localparam int SEC_OFF_W    = $clog2(SECTOR_BYTES);
    localparam int NUM_WAYS     = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_CAST,
        ST_INV
    } fl_state_e;

    function automatic int sec_bits(input int sectors);
        return (sectors > 1) ? $clog2(sectors) : 0;
    endfunction

endpackage

// File: rtl/cflush_walk_ctr.sv
module cflush_walk_ctr #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             step,
    output logic             way,
    output logic [IDX_W-1:0] idx,
    output logic             walk_last
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic             way_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            way_q <= 1'b0;
            idx_q <= '0;
        end else if (step) begin
            if (idx_q == IDX_MAX) begin
                idx_q <= '0;
                way_q <= 1'b1;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign way       = way_q;
    assign idx       = idx_q;
    assign walk_last = way_q && (idx_q == IDX_MAX);

    // R3: the way moves to 1 only as the index wraps to zero
    assert_way_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !start && !walk_last && idx_q == IDX_MAX) |=> (way_q && idx_q == '0));

endmodule

// File: rtl/cflush_line_reg.sv
module cflush_line_reg #(
    parameter int TAG_W   = 12,
    parameter int SECTORS = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               sec_adv,
    input  logic               valid_in,
    input  logic [SECTORS-1:0] dirty_in,
    input  logic [TAG_W-1:0]   tag_in,
    output logic               cur_dirty,
    output logic               sec_last,
    output logic [TAG_W-1:0]   tag_q,
    output logic [(SECTORS>1 ? $clog2(SECTORS) : 1)-1:0] sec
);
    localparam int PTR_W = (SECTORS > 1) ? $clog2(SECTORS) : 1;

    logic               valid_q;
    logic [SECTORS-1:0] dirty_q;
    logic [PTR_W-1:0]   sec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            dirty_q <= '0;
            tag_q   <= '0;
            sec_q   <= '0;
        end else if (load) begin
            valid_q <= valid_in;
            dirty_q <= dirty_in;
            tag_q   <= tag_in;
            sec_q   <= '0;
        end else if (sec_adv) begin
            sec_q <= sec_q + 1'b1;
        end
    end

    assign cur_dirty = valid_q && dirty_q[sec_q];
    assign sec_last  = (sec_q == PTR_W'(SECTORS - 1));
    assign sec       = sec_q;

    // R4: the sector pointer never steps past the last sector
    assert_sec_range_R4: assert property (@(posedge clk) disable iff (rst)
        sec_adv |-> !sec_last);

endmodule

// File: rtl/cflush_fsm.sv
module cflush_fsm
    import cflush_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush_set,
    input  logic snoop_req,
    input  logic cur_dirty,
    input  logic sec_last,
    input  logic walk_last,
    input  logic co_ack,
    output logic busy,
    output logic tag_rd_en,
    output logic tag_inv_en,
    output logic line_load,
    output logic sec_adv,
    output logic walk_step,
    output logic walk_start,
    output logic co_req
);
    fl_state_e st, nxt;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= nxt;
    end

    always_comb begin
        nxt        = st;
        tag_rd_en  = 1'b0;
        tag_inv_en = 1'b0;
        line_load  = 1'b0;
        sec_adv    = 1'b0;
        walk_step  = 1'b0;
        walk_start = 1'b0;
        co_req     = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (flush_set) begin
                    walk_start = 1'b1;
                    nxt        = ST_READ;
                end
            end
            ST_READ: begin
                if (!snoop_req) begin
                    tag_rd_en = 1'b1;
                    line_load = 1'b1;
                    nxt       = ST_CAST;
                end
            end
            ST_CAST: begin
                co_req = cur_dirty;
                if (!cur_dirty || co_ack) begin
                    if (sec_last) nxt = ST_INV;
                    else          sec_adv = 1'b1;
                end
            end
            ST_INV: begin
                if (!snoop_req) begin
                    tag_inv_en = 1'b1;
                    if (walk_last) begin
                        nxt = ST_IDLE;
                    end else begin
                        walk_step = 1'b1;
                        nxt       = ST_READ;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign busy = (st != ST_IDLE);

    // R2: a flush only begins after a software request
    assert_start_by_request_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(flush_set));

    // R8: the bit clears only after the final invalidation
    assert_clear_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tag_inv_en && walk_last));

    // R7: a snoop cycle is never used by the sequencer
    assert_snoop_owns_port_R7: assert property (@(posedge clk) disable iff (rst)
        snoop_req |-> !(tag_rd_en || tag_inv_en));

endmodule

// File: rtl/cflush_top.sv
module cflush_top
    import cflush_pkg::*;
#(
    parameter int IDX_W   = 7,
    parameter int TAG_W   = 12,
    parameter int SECTORS = 2,
    localparam int SB     = sec_bits(SECTORS),
    localparam int ADDR_W = TAG_W + IDX_W + SB + SEC_OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush_set,
    output logic               flush_active,
    output logic               l1_block,
    input  logic               snoop_req,
    output logic               snoop_gnt,
    output logic               tag_rd_en,
    output logic               tag_inv_en,
    output logic               tag_way,
    output logic [IDX_W-1:0]   tag_idx,
    input  logic               tag_rd_valid,
    input  logic [SECTORS-1:0] tag_rd_dirty,
    input  logic [TAG_W-1:0]   tag_rd_tag,
    output logic               co_req,
    output logic               co_way,
    output logic [ADDR_W-1:0]  co_addr,
    input  logic               co_ack
);
    localparam int PTR_W = (SECTORS > 1) ? $clog2(SECTORS) : 1;

    logic             busy, line_load, sec_adv, walk_step, walk_start;
    logic             cur_dirty, sec_last, walk_last;
    logic [TAG_W-1:0] line_tag;
    logic [PTR_W-1:0] sec;

    cflush_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .flush_set  (flush_set),
        .snoop_req  (snoop_req),
        .cur_dirty  (cur_dirty),
        .sec_last   (sec_last),
        .walk_last  (walk_last),
        .co_ack     (co_ack),
        .busy       (busy),
        .tag_rd_en  (tag_rd_en),
        .tag_inv_en (tag_inv_en),
        .line_load  (line_load),
        .sec_adv    (sec_adv),
        .walk_step  (walk_step),
        .walk_start (walk_start),
        .co_req     (co_req)
    );

    cflush_walk_ctr #(.IDX_W(IDX_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .start     (walk_start),
        .step      (walk_step),
        .way       (tag_way),
        .idx       (tag_idx),
        .walk_last (walk_last)
    );

    cflush_line_reg #(.TAG_W(TAG_W), .SECTORS(SECTORS)) u_line (
        .clk       (clk),
        .rst       (rst),
        .load      (line_load),
        .sec_adv   (sec_adv),
        .valid_in  (tag_rd_valid),
        .dirty_in  (tag_rd_dirty),
        .tag_in    (tag_rd_tag),
        .cur_dirty (cur_dirty),
        .sec_last  (sec_last),
        .tag_q     (line_tag),
        .sec       (sec)
    );

    generate
        if (SB > 0) begin : g_multi_sector
            assign co_addr = {line_tag, tag_idx, sec[SB-1:0], {SEC_OFF_W{1'b0}}};
        end else begin : g_single_sector
            logic unused_sec;
            assign unused_sec = ^sec;
            assign co_addr = {line_tag, tag_idx, {SEC_OFF_W{1'b0}}};
        end
    endgenerate

    assign co_way       = tag_way;
    assign flush_active = busy;
    assign l1_block     = busy;
    assign snoop_gnt    = snoop_req;

    // R5: a pending castout holds its request and address until accepted
    assert_castout_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (co_req && !co_ack) |=> (co_req && $stable(co_addr) && $stable(co_way)));

    // R9: level-one traffic is held exactly while flushing
    assert_l1_block_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(flush_active) |-> l1_block);

endmodule

// File: tb/cflush_top_tb_top.sv
module cflush_top_tb_top;
    localparam int IDX_W  = 7;
    localparam int TAG_W  = 12;
    localparam int SECT   = 2;
    localparam int NSETS  = 1 << IDX_W;
    localparam int ADDR_W = TAG_W + IDX_W + 1 + 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush_set = 1'b0, snoop_req = 1'b0, co_ack = 1'b0;
    logic flush_active, l1_block, snoop_gnt, tag_rd_en, tag_inv_en, tag_way, co_req, co_way;
    logic [IDX_W-1:0]  tag_idx;
    logic              tag_rd_valid;
    logic [SECT-1:0]   tag_rd_dirty;
    logic [TAG_W-1:0]  tag_rd_tag;
    logic [ADDR_W-1:0] co_addr;

    logic             tv [2][NSETS];
    logic [SECT-1:0]  td [2][NSETS];
    logic [TAG_W-1:0] tt [2][NSETS];

    int checks = 0, errors = 0, cyc = 0;
    int exp_rd = 0, exp_inv = 0;
    bit mon_on = 1'b0;
    bit pend = 1'b0;
    logic [ADDR_W:0] pend_item;
    logic [ADDR_W:0] exp_q[$];

    always #2 clk = ~clk;

    cflush_top #(.IDX_W(IDX_W), .TAG_W(TAG_W), .SECTORS(SECT)) dut_i (
        .clk(clk), .rst(rst), .flush_set(flush_set), .flush_active(flush_active),
        .l1_block(l1_block), .snoop_req(snoop_req), .snoop_gnt(snoop_gnt),
        .tag_rd_en(tag_rd_en), .tag_inv_en(tag_inv_en), .tag_way(tag_way),
        .tag_idx(tag_idx), .tag_rd_valid(tag_rd_valid), .tag_rd_dirty(tag_rd_dirty),
        .tag_rd_tag(tag_rd_tag), .co_req(co_req), .co_way(co_way),
        .co_addr(co_addr), .co_ack(co_ack)
    );

    assign tag_rd_valid = tv[tag_way][tag_idx];
    assign tag_rd_dirty = td[tag_way][tag_idx];
    assign tag_rd_tag   = tt[tag_way][tag_idx];

    always @(posedge clk) begin
        if (tag_inv_en) begin
            tv[tag_way][tag_idx] <= 1'b0;
            td[tag_way][tag_idx] <= '0;
        end
    end

    // stimulus for snoops and acknowledges, driven just after each edge
    always @(posedge clk) begin
        #1;
        cyc       <= cyc + 1;
        snoop_req <= (cyc % 7 == 3);
        co_ack    <= (cyc % 3 != 0);
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: fill the array and queue the expected castouts in walk order
    task automatic load_array(input int mode);
        for (int w = 0; w < 2; w++) begin
            for (int i = 0; i < NSETS; i++) begin
                case (mode)
                    0: begin
                        tv[w][i] = (i % 5 != 0);
                        td[w][i] = {1'((i >> 1) ^ w), 1'(i % 3 == 0)};
                    end
                    1: begin tv[w][i] = 1'b1; td[w][i] = 2'b00; end
                    default: begin tv[w][i] = 1'b1; td[w][i] = 2'b11; end
                endcase
                tt[w][i] = TAG_W'(i * 7 + w * 1000 + mode * 33);
                for (int s = 0; s < SECT; s++)
                    if (tv[w][i] && td[w][i][s])
                        exp_q.push_back({1'(w), tt[w][i], IDX_W'(i), 1'(s), 5'b0});
            end
        end
    endtask

    // monitor: compares port activity against the scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (snoop_req) begin
                chk(snoop_gnt == 1'b1, "R7 gnt", snoop_gnt, 1);
                chk(!tag_rd_en && !tag_inv_en, "R7 port", {tag_rd_en, tag_inv_en}, 0);
            end
            chk(l1_block == flush_active, "R9", l1_block, flush_active);
            if (tag_rd_en) begin
                chk({tag_way, tag_idx} == 8'(exp_rd) && exp_rd < 2 * NSETS, "R3",
                    {tag_way, tag_idx}, exp_rd);
                exp_rd++;
            end
            if (tag_inv_en) begin
                chk({tag_way, tag_idx} == 8'(exp_inv) && exp_inv < exp_rd, "R6 order",
                    {tag_way, tag_idx}, exp_inv);
                exp_inv++;
            end
            if (pend)
                chk(co_req && {co_way, co_addr} == pend_item, "R5",
                    {co_req, co_way, co_addr}, {1'b1, pend_item});
            if (co_req && co_ack) begin
                if (exp_q.size() == 0) chk(1'b0, "R4 extra castout", {co_way, co_addr}, 0);
                else begin
                    logic [ADDR_W:0] e;
                    e = exp_q.pop_front();
                    chk({co_way, co_addr} == e, "R4", {co_way, co_addr}, e);
                end
            end
            pend      = co_req && !co_ack;
            pend_item = {co_way, co_addr};
        end
    end

    task automatic run_flush(input int mode, input bit poke);
        int n;
        bit timed_out;
        load_array(mode);
        exp_rd  = 0;
        exp_inv = 0;
        @(posedge clk); #1 flush_set = 1'b1;
        @(posedge clk); #1 flush_set = 1'b0;
        @(negedge clk);
        chk(flush_active == 1'b1, "R2 start", flush_active, 1);
        chk(l1_block == 1'b1, "R9 start", l1_block, 1);
        n = 0;
        timed_out = 1'b0;
        while (flush_active && !timed_out) begin
            @(negedge clk);
            n++;
            if (poke && n == 300) begin
                @(posedge clk); #1 flush_set = 1'b1;
                @(posedge clk); #1 flush_set = 1'b0;
            end
            if (!flush_active && exp_inv != 2 * NSETS)
                chk(1'b0, "R8 early clear", exp_inv, 2 * NSETS);
            if (n > 20000) timed_out = 1'b1;
        end
        chk(!timed_out, "R8 watchdog", n, 0);
        chk(exp_rd == 2 * NSETS, "R3 count", exp_rd, 2 * NSETS);
        chk(exp_inv == 2 * NSETS, "R6 count", exp_inv, 2 * NSETS);
        chk(exp_q.size() == 0, "R4 missing castouts", exp_q.size(), 0);
        begin
            int still_valid = 0;
            for (int w = 0; w < 2; w++)
                for (int i = 0; i < NSETS; i++)
                    if (tv[w][i]) still_valid++;
            chk(still_valid == 0, "R6 all invalid", still_valid, 0);
        end
        exp_q.delete();
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(!flush_active && !co_req && !tag_rd_en, "R8 stays idle",
                {flush_active, co_req, tag_rd_en}, 0);
        end
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < NSETS; i++) begin
                tv[w][i] = 1'b0; td[w][i] = '0; tt[w][i] = '0;
            end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!flush_active && !l1_block, "R1 idle", {flush_active, l1_block}, 0);
        chk(!co_req && !tag_rd_en && !tag_inv_en, "R1 strobes",
            {co_req, tag_rd_en, tag_inv_en}, 0);
        mon_on = 1'b1;
        run_flush(0, 1'b1);
        run_flush(1, 1'b0);
        run_flush(2, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule